// File: doc/BRIEF.md
# CAN Fault-Confinement Status Flags

This block keeps the fault-confinement state of a CAN node and drives three global status flags from it. The flags are bus-off, error warning and transmitter idle. It holds a 9-bit transmit error count and an 8-bit receive error count. It moves these counts on error and success events, and it puts the node into bus-off when the transmit count reaches 256. While the node is in bus-off, it reuses the receive count to tally runs of eleven recessive bits, and the node leaves bus-off once 128 such runs have been seen.

Frame-level logic upstream drives the block with single-cycle strobes, one for each bit-time event. These strobes cover the start of an own frame, the end-of-frame and intermission bit positions, arbitration loss, reception start, bus idle, halt, and the recessive/dominant level of each bit during recovery. The block has no data stream, so every pin is plain control or status with no valid/ready handshake. Only the low eight bits of the transmit count are visible. The ninth bit is the bus-off flag itself.

Top module: `can_fault_status`

## Requirements
- R1: A `tx_err` pulse adds 8 to the transmit count. A successful transmission (a `tx_ack` cycle) subtracts 1, and the count never goes below 0. When both happen in one cycle, the net change is +7. `tec_view` shows bits 7..0 of the count.
- R2: When the transmit count would reach 256 or more, it stops at 256 and `busoff` rises. `tec_view` then reads 0. While in bus-off, `tx_err` has no effect.
- R3: Outside bus-off, `warn` is 1 when either count is 96 or more, and 0 when both counts are below 96.
- R4: `warn` is 0 whenever `busoff` is 1.
- R5: A `rx_err` pulse adds 1 to the receive count and a `rx_ok` pulse subtracts 1, with the count held to 0..255. When both arrive together, the count does not change. Both pulses are ignored in bus-off.
- R6: Entering bus-off clears the receive count. In bus-off, each run of 11 consecutive `bit_stb` cycles with `bit_rec`=1 (recessive) adds one to the receive count. A cycle with `bit_stb` and `bit_rec`=0 restarts the run. Completing the 128th run clears both counts, drops `busoff` and sets `tx_idle`.
- R7: `tx_sof` outside bus-off clears `tx_idle`. `tx_idle` reads 0 throughout bus-off.
- R8: `tx_ack` is high in the cycle where `eof_stb` is 1 and `eof_pos`=6 (the seventh end-of-frame bit, counted from 0), while a transmission is active and the node is not in bus-off. Other positions give 0.
- R9: `ifs_stb` with `ifs_pos`=2 (the third intermission bit, counted from 0) sets `tx_idle` only if `tx_pending` is 0. Other positions have no effect.
- R10: `arb_lost`, `bus_idle`, `rx_start` and `halt_req` each set `tx_idle`. If one of them arrives in the same cycle as `tx_sof`, setting wins.
- R11: Both `rst_n` low and a `soft_rst` pulse clear both counts. After either, `busoff`=0, `warn`=0 and `tx_idle`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset pulse |
| tx_sof | input | 1 | Start of a frame this node transmits |
| tx_err | input | 1 | Error detected while transmitting |
| tx_pending | input | 1 | Another message is queued for transmission |
| eof_stb | input | 1 | End-of-frame bit strobe |
| eof_pos | input | 3 | End-of-frame bit index, from 0 |
| ifs_stb | input | 1 | Intermission bit strobe |
| ifs_pos | input | 2 | Intermission bit index, from 0 |
| arb_lost | input | 1 | Arbitration lost |
| bus_idle | input | 1 | Bus idle detected |
| rx_start | input | 1 | Reception of a frame began |
| halt_req | input | 1 | Transition into halt |
| rx_err | input | 1 | Error detected while receiving |
| rx_ok | input | 1 | Frame received without error |
| bit_stb | input | 1 | Bit-time strobe for recovery counting |
| bit_rec | input | 1 | Sampled bus level, 1 = recessive |
| busoff | output | 1 | Node is in bus-off |
| warn | output | 1 | Error warning |
| tx_idle | output | 1 | Not in bus-off and no transmission in progress |
| tx_ack | output | 1 | Successful transmission strobe |
| tec_view | output | 8 | Low eight bits of the transmit error count |

## Verification
The transmit count can be raised by a transmit error and lowered by a successful transmission in the same cycle. The bench provokes this by asserting `tx_err` together with the seventh end-of-frame strobe during an own frame, and it expects the count to rise by exactly 7. The second collision is on the idle flag: a release event (arbitration loss) arriving with an own start-of-frame must leave `tx_idle` at 1. Opposing receive events in the same cycle must leave the receive count unchanged. The bench judges this through the warning threshold at 95/96.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int unsigned TEC_W        = 9;
  localparam int unsigned REC_W        = 8;
  localparam int unsigned WARN_LIMIT   = 96;
  localparam int unsigned TX_ERR_STEP  = 8;
  localparam int unsigned RUN_LEN      = 11;
  localparam int unsigned RECOV_RUNS   = 128;
  localparam int unsigned EOF_POS_W    = 3;
  localparam int unsigned IFS_POS_W    = 2;
  localparam int unsigned ACK_EOF_POS  = 6;
  localparam int unsigned IDLE_IFS_POS = 2;

  // Events that end (or abandon) an own transmission
  typedef struct packed {
    logic arb_lost;
    logic bus_idle;
    logic rx_start;
    logic halt;
  } release_ev_t;
endpackage

// File: rtl/cfs_tec.sv
module cfs_tec #(
  parameter int unsigned W    = 9,
  parameter int unsigned STEP = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         inc,
  input  logic         dec,
  input  logic         recover,
  output logic [W-1:0] tec
);
  localparam int unsigned SUM_W = W + 1;
  localparam logic [W-1:0] CAP = W'(1) << (W - 1);

  logic             off;
  logic [SUM_W-1:0] sum;
  logic [W-1:0]     nxt;

  assign off = tec[W-1];

  always_comb begin
    sum = {1'b0, tec} + (inc ? SUM_W'(STEP) : '0);
    if (dec && (sum != '0)) sum = sum - SUM_W'(1);
    nxt = (sum >= {1'b0, CAP}) ? CAP : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec <= '0;
    end else if (soft_rst || recover) begin
      tec <= '0;
    end else if (!off && (inc || dec)) begin
      tec <= nxt;
    end
  end
endmodule

// File: rtl/cfs_rec.sv
module cfs_rec #(
  parameter int unsigned W       = 8,
  parameter int unsigned RUN_LEN = 11,
  parameter int unsigned RUNS    = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         busoff,
  input  logic         rx_err,
  input  logic         rx_ok,
  input  logic         bit_stb,
  input  logic         bit_rec,
  output logic [W-1:0] rec,
  output logic         recover
);
  localparam int unsigned RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;

  logic [RUN_W-1:0] run;
  logic             busoff_d;
  logic             entering;
  logic             run_done;

  assign entering = busoff && !busoff_d;
  assign run_done = busoff && !entering && bit_stb && bit_rec &&
                    (run == RUN_W'(RUN_LEN - 1));
  assign recover  = run_done && (rec == W'(RUNS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec      <= '0;
      run      <= '0;
      busoff_d <= 1'b0;
    end else begin
      busoff_d <= busoff && !soft_rst;
      if (soft_rst || entering || recover) begin
        rec <= '0;
        run <= '0;
      end else if (busoff) begin
        if (bit_stb) begin
          if (!bit_rec) begin
            run <= '0;
          end else if (run_done) begin
            run <= '0;
            rec <= rec + W'(1);
          end else begin
            run <= run + RUN_W'(1);
          end
        end
      end else begin
        run <= '0;
        case ({rx_err, rx_ok})
          2'b10:   if (rec != '1) rec <= rec + W'(1);
          2'b01:   if (rec != '0) rec <= rec - W'(1);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfs_txtrack.sv
module cfs_txtrack
  import cfs_pkg::*;
#(
  parameter int unsigned EOF_W    = 3,
  parameter int unsigned IFS_W    = 2,
  parameter int unsigned ACK_POS  = 6,
  parameter int unsigned IDLE_POS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             busoff,
  input  logic             recover,
  input  logic             tx_sof,
  input  logic             eof_stb,
  input  logic [EOF_W-1:0] eof_pos,
  input  logic             ifs_stb,
  input  logic [IFS_W-1:0] ifs_pos,
  input  logic             tx_pending,
  input  release_ev_t      rel,
  output logic             tx_idle,
  output logic             tx_ack
);
  logic idle_q;
  logic release_now;

  always_comb begin
    release_now = soft_rst || recover || (|rel) ||
                  (ifs_stb && (ifs_pos == IFS_W'(IDLE_POS)) && !tx_pending);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b1;
    end else if (release_now) begin
      idle_q <= 1'b1;
    end else if (tx_sof && !busoff) begin
      idle_q <= 1'b0;
    end
  end

  assign tx_idle = idle_q && !busoff;
  assign tx_ack  = eof_stb && (eof_pos == EOF_W'(ACK_POS)) && !idle_q && !busoff;
endmodule

// File: rtl/can_fault_status.sv
module can_fault_status
  import cfs_pkg::*;
#(
  parameter int unsigned WARN_AT  = WARN_LIMIT,
  parameter int unsigned ERR_STEP = TX_ERR_STEP,
  parameter int unsigned RUN_BITS = RUN_LEN,
  parameter int unsigned RUN_CNT  = RECOV_RUNS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 tx_sof,
  input  logic                 tx_err,
  input  logic                 tx_pending,
  input  logic                 eof_stb,
  input  logic [EOF_POS_W-1:0] eof_pos,
  input  logic                 ifs_stb,
  input  logic [IFS_POS_W-1:0] ifs_pos,
  input  logic                 arb_lost,
  input  logic                 bus_idle,
  input  logic                 rx_start,
  input  logic                 halt_req,
  input  logic                 rx_err,
  input  logic                 rx_ok,
  input  logic                 bit_stb,
  input  logic                 bit_rec,
  output logic                 busoff,
  output logic                 warn,
  output logic                 tx_idle,
  output logic                 tx_ack,
  output logic [TEC_W-2:0]     tec_view
);
  logic [TEC_W-1:0] tec;
  logic [REC_W-1:0] rec;
  logic             recover;
  release_ev_t      rel;

  assign rel      = '{arb_lost: arb_lost, bus_idle: bus_idle, rx_start: rx_start, halt: halt_req};
  assign busoff   = tec[TEC_W-1];
  assign tec_view = tec[TEC_W-2:0];
  assign warn     = !busoff && ((tec >= TEC_W'(WARN_AT)) || (rec >= REC_W'(WARN_AT)));

  cfs_tec #(.W(TEC_W), .STEP(ERR_STEP)) u_tec (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .inc      (tx_err),
    .dec      (tx_ack),
    .recover  (recover),
    .tec      (tec)
  );

  cfs_rec #(.W(REC_W), .RUN_LEN(RUN_BITS), .RUNS(RUN_CNT)) u_rec (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .busoff   (busoff),
    .rx_err   (rx_err),
    .rx_ok    (rx_ok),
    .bit_stb  (bit_stb),
    .bit_rec  (bit_rec),
    .rec      (rec),
    .recover  (recover)
  );

  cfs_txtrack #(
    .EOF_W    (EOF_POS_W),
    .IFS_W    (IFS_POS_W),
    .ACK_POS  (ACK_EOF_POS),
    .IDLE_POS (IDLE_IFS_POS)
  ) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .busoff     (busoff),
    .recover    (recover),
    .tx_sof     (tx_sof),
    .eof_stb    (eof_stb),
    .eof_pos    (eof_pos),
    .ifs_stb    (ifs_stb),
    .ifs_pos    (ifs_pos),
    .tx_pending (tx_pending),
    .rel        (rel),
    .tx_idle    (tx_idle),
    .tx_ack     (tx_ack)
  );
endmodule

// File: rtl/cfs_checker.sv
module cfs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       tx_err,
  input logic       halt_req,
  input logic       busoff,
  input logic       warn,
  input logic       tx_idle,
  input logic       tx_ack,
  input logic [7:0] tec_view
);
  // R4
  warn_off_in_busoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busoff |-> !warn);

  // R7
  idle_low_in_busoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busoff |-> !tx_idle);

  // R8
  ack_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |-> (!tx_idle && !busoff));

  // R2
  busoff_entry_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busoff) |-> (tec_view == 8'd0));

  // R11
  soft_reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busoff && tx_idle && tec_view == 8'd0));

  // R10
  halt_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !soft_rst) |=> (tx_idle || busoff));

  // R1
  tec_step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !tx_ack && !busoff && !soft_rst) |=>
      (busoff || tec_view == $past(tec_view) + 8'd8));
endmodule

bind can_fault_status cfs_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .soft_rst (soft_rst),
  .tx_err   (tx_err),
  .halt_req (halt_req),
  .busoff   (busoff),
  .warn     (warn),
  .tx_idle  (tx_idle),
  .tx_ack   (tx_ack),
  .tec_view (tec_view)
);

// File: tb/can_fault_status_test.sv
`timescale 1ns/1ps
module can_fault_status_test;
  logic clk = 1'b0;
  logic rst_n, soft_rst, tx_sof, tx_err, tx_pending, eof_stb, ifs_stb;
  logic arb_lost, bus_idle, rx_start, halt_req, rx_err, rx_ok, bit_stb, bit_rec;
  logic [2:0] eof_pos;
  logic [1:0] ifs_pos;
  logic busoff, warn, tx_idle, tx_ack;
  logic [7:0] tec_view;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_fault_status uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_sof(tx_sof), .tx_err(tx_err),
    .tx_pending(tx_pending), .eof_stb(eof_stb), .eof_pos(eof_pos), .ifs_stb(ifs_stb),
    .ifs_pos(ifs_pos), .arb_lost(arb_lost), .bus_idle(bus_idle), .rx_start(rx_start),
    .halt_req(halt_req), .rx_err(rx_err), .rx_ok(rx_ok), .bit_stb(bit_stb),
    .bit_rec(bit_rec), .busoff(busoff), .warn(warn), .tx_idle(tx_idle),
    .tx_ack(tx_ack), .tec_view(tec_view)
  );

  // events: sof err ack ifs3 pend rxe rxo arb | expected tec | busoff warn idle
  typedef struct packed {
    logic [7:0] ev;
    logic [7:0] tec;
    logic [2:0] flg;
  } vec_t;

  function automatic vec_t mk(input logic [7:0] e, input logic [7:0] t, input logic [2:0] f);
    return '{ev: e, tec: t, flg: f};
  endfunction

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    mk(8'b10000000, 8'd0,   3'b000),
    mk(8'b00100000, 8'd0,   3'b000),
    mk(8'b00010000, 8'd0,   3'b001),
    mk(8'b10000000, 8'd0,   3'b000),
    mk(8'b01000000, 8'd8,   3'b000),
    mk(8'b01000000, 8'd16,  3'b000),
    mk(8'b01000000, 8'd24,  3'b000),
    mk(8'b01000000, 8'd32,  3'b000),
    mk(8'b01000000, 8'd40,  3'b000),
    mk(8'b01000000, 8'd48,  3'b000),
    mk(8'b01000000, 8'd56,  3'b000),
    mk(8'b01000000, 8'd64,  3'b000),
    mk(8'b01000000, 8'd72,  3'b000),
    mk(8'b01000000, 8'd80,  3'b000),
    mk(8'b01000000, 8'd88,  3'b000),
    mk(8'b01000000, 8'd96,  3'b010),
    mk(8'b00100000, 8'd95,  3'b000),
    mk(8'b00011000, 8'd95,  3'b000),
    mk(8'b00000001, 8'd95,  3'b001),
    mk(8'b10000000, 8'd95,  3'b000),
    mk(8'b01100000, 8'd102, 3'b010),
    mk(8'b00000100, 8'd102, 3'b010),
    mk(8'b00000110, 8'd102, 3'b010),
    mk(8'b00010000, 8'd102, 3'b011)
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    soft_rst = 0; tx_sof = 0; tx_err = 0; tx_pending = 0; eof_stb = 0; eof_pos = 0;
    ifs_stb = 0; ifs_pos = 0; arb_lost = 0; bus_idle = 0; rx_start = 0; halt_req = 0;
    rx_err = 0; rx_ok = 0; bit_stb = 0; bit_rec = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    clear_in();
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #500000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    clear_in();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R11 reset tec", tec_view, 0);
    chk("R11 reset busoff", busoff, 0);
    chk("R11 reset warn", warn, 0);
    chk("R11 reset idle", tx_idle, 1);
    chk("R8 reset ack", tx_ack, 0);

    // table: R1 counting, R3 warn, R9/R10 idle release, R5 receive events
    for (int i = 0; i < NV; i++) begin
      {tx_sof, tx_err, eof_stb, ifs_stb, tx_pending, rx_err, rx_ok, arb_lost} = VECS[i].ev;
      eof_pos = VECS[i].ev[5] ? 3'd6 : 3'd0;
      ifs_pos = VECS[i].ev[4] ? 2'd2 : 2'd0;
      cyc();
      chk($sformatf("R1 vec%0d tec", i), tec_view, VECS[i].tec);
      chk($sformatf("R2 vec%0d busoff", i), busoff, VECS[i].flg[2]);
      chk($sformatf("R3 vec%0d warn", i), warn, VECS[i].flg[1]);
      chk($sformatf("R9 vec%0d idle", i), tx_idle, VECS[i].flg[0]);
    end

    // R8: ack only at end-of-frame index 6
    tx_sof = 1; cyc();
    eof_stb = 1; eof_pos = 3'd5; #1;
    chk("R8 ack at pos5", tx_ack, 0);
    eof_pos = 3'd6; #1;
    chk("R8 ack at pos6", tx_ack, 1);
    cyc();
    chk("R1 tec after ack", tec_view, 101);

    // R9: wrong intermission index ignored
    ifs_stb = 1; ifs_pos = 2'd1; cyc();
    chk("R9 idle at ifs1", tx_idle, 0);
    ifs_stb = 1; ifs_pos = 2'd2; cyc();
    chk("R9 idle at ifs2", tx_idle, 1);
    eof_stb = 1; eof_pos = 3'd6; #1;
    chk("R8 no ack when idle", tx_ack, 0);
    cyc();
    chk("R8 tec unchanged when idle", tec_view, 101);

    // R10 release events
    tx_sof = 1; cyc();
    chk("R7 sof clears idle", tx_idle, 0);
    bus_idle = 1; cyc();
    chk("R10 bus idle", tx_idle, 1);
    tx_sof = 1; cyc();
    rx_start = 1; cyc();
    chk("R10 rx start", tx_idle, 1);
    tx_sof = 1; cyc();
    halt_req = 1; cyc();
    chk("R10 halt", tx_idle, 1);
    tx_sof = 1; arb_lost = 1; cyc();
    chk("R10 release beats sof", tx_idle, 1);

    // R11 soft reset
    tx_sof = 1; cyc();
    soft_rst = 1; cyc();
    chk("R11 soft tec", tec_view, 0);
    chk("R11 soft busoff", busoff, 0);
    chk("R11 soft idle", tx_idle, 1);
    chk("R11 soft warn", warn, 0);

    // R3/R5 receive count threshold
    for (int i = 0; i < 95; i++) begin rx_err = 1; cyc(); end
    chk("R3 rec 95", warn, 0);
    rx_err = 1; cyc();
    chk("R3 rec 96", warn, 1);
    rx_ok = 1; cyc();
    chk("R5 rec down", warn, 0);
    rx_err = 1; rx_ok = 1; cyc();
    chk("R5 both events", warn, 0);
    rx_err = 1; cyc();
    chk("R5 rec 96 again", warn, 1);

    // R2 bus-off entry
    tx_sof = 1; cyc();
    for (int i = 0; i < 31; i++) begin tx_err = 1; cyc(); end
    chk("R2 tec 248", tec_view, 248);
    chk("R2 not yet busoff", busoff, 0);
    tx_err = 1; cyc();
    chk("R2 busoff set", busoff, 1);
    chk("R2 view zero", tec_view, 0);
    chk("R4 warn off", warn, 0);
    chk("R7 idle off", tx_idle, 0);
    cyc();
    tx_err = 1; cyc();
    chk("R2 err ignored", tec_view, 0);
    chk("R2 still busoff", busoff, 1);
    arb_lost = 1; cyc();
    chk("R7 idle held low", tx_idle, 0);
    rx_err = 1; cyc();
    eof_stb = 1; eof_pos = 3'd6; #1;
    chk("R8 no ack in busoff", tx_ack, 0);
    cyc();

    // R6 recovery: broken run, then 128 full runs
    for (int i = 0; i < 10; i++) begin bit_stb = 1; bit_rec = 1; cyc(); end
    bit_stb = 1; bit_rec = 0; cyc();
    for (int i = 0; i < 128 * 11 - 1; i++) begin bit_stb = 1; bit_rec = 1; cyc(); end
    chk("R6 one bit short", busoff, 1);
    bit_stb = 1; bit_rec = 1; cyc();
    chk("R6 recovered", busoff, 0);
    chk("R6 tec cleared", tec_view, 0);
    chk("R6 rec cleared", warn, 0);
    chk("R6 idle set", tx_idle, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule